// File: doc/BRIEF.md
# AEGIS-128 State Update Engine

This block keeps the 640-bit running state of the AEGIS-128 authenticated cipher as five 128-bit words and advances the whole state by one update step per clock. An update step runs five AES rounds in parallel. The rounds use no round key, and each round reads one state word. The results are folded back into the ring of words, and one 128-bit input word is absorbed into word 0. A surrounding datapath feeds message or associated-data words through the update strobe and reads the full state back to form keystream and tags.

The block also runs key and IV setup. A start pulse loads the starting state from the key, the IV and two fixed constants. The block then steps ten times by itself, with the key and the key XOR IV as inputs in turn. While it does this it holds busy high, and it raises a one-cycle done pulse when the setup ends. The key and IV inputs must stay stable while busy is high.

Byte convention: byte i of any 128-bit word sits in bits [8i+7:8i]. State word Sj sits in bits [128j+127:128j] of the state output.

Top module: `aegis128_state_engine`

## Requirements
- R1: After reset the state output is all zero, and busy and init_done are low.
- R2: When init_start is high while busy is low, the next cycle shows S0 = K^IV, S1 = C1, S2 = C0, S3 = K^C0 and S4 = K^C1. Here C0 is bytes 0..15 = 00 01 01 02 03 05 08 0d 15 22 37 59 90 e9 79 62 and C1 is bytes 0..15 = db 3d 18 55 6d c2 2f f1 20 11 31 42 73 b5 28 dd.
- R3: Busy is high for exactly ten cycles after the loaded state appears. init_done is high for exactly the one cycle in which busy first reads low again.
- R4: The ten setup steps use the input word K on the first, third, fifth, seventh and ninth steps, and K^IV on the other five. One step is applied per busy cycle.
- R5: When idle with upd_valid high, one update step is applied with M = upd_msg: S0' = S0^R(S4)^M and Sj' = Sj^R(Sj-1) for j = 1..4, all from old values. R is ShiftRows (output byte i takes input byte (i+4*(i mod 4)) mod 16), then the AES S-box, then MixColumns on columns of bytes 4c..4c+3 using doubling with reduction 0x1B. So an all-zero state updated with M = 0 becomes 0x63 in every byte.
- R6: Update strobes and start pulses that arrive while busy is high have no effect on the state or on the setup sequence.
- R7: When idle with neither strobe high, the state holds its value.
- R8: If init_start and upd_valid are high together while idle, the setup starts and the update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start | input | 1 | Begin key/IV setup |
| key | input | 128 | Cipher key, held stable during setup |
| iv | input | 128 | Initialization vector, held stable during setup |
| upd_valid | input | 1 | Apply one update step with upd_msg |
| upd_msg | input | 128 | Word absorbed by an update step |
| state_out | output | 640 | S0..S4, S0 in the low bits |
| busy | output | 1 | Setup steps in progress |
| init_done | output | 1 | One-cycle pulse when setup ends |

## Verification
The hardest case to reach is a strobe that collides with the internal setup sequence. This covers an update or a second start during the ten busy cycles, and a start and an update in the same idle cycle. The stimulus drives both strobes on chosen busy cycles, including the first and the last. After each one it compares the full state against a behavioural model on every clock. Setup runs twice with different keys, so a wrong K/K^IV alternation or a step count off by one shows up in the final state.

// File: rtl/aegis_pkg.sv
package aegis_pkg;
    localparam int BLK_BYTES = 16;
    localparam int BLK_W     = BLK_BYTES * 8;
    localparam int NWORDS    = 5;

    typedef logic [BLK_W-1:0]        blk_t;
    typedef blk_t [NWORDS-1:0]       state_t;

    localparam blk_t CONST0 = 128'h6279e990_59372215_0d080503_02010100;
    localparam blk_t CONST1 = 128'hdd28b573_42311120_f12fc26d_55183ddb;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // multiplicative inverse as x^254, then the affine map
    function automatic logic [7:0] sbox_calc(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        e = 8'd254;
        r = 8'h01;
        p = x;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
    endfunction
endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    always_comb begin
        dout = aegis_pkg::sbox_calc(din);
    end
endmodule

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
    import aegis_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    localparam int NCOL = BLK_BYTES / 4;

    logic [7:0] shifted [BLK_BYTES];
    logic [7:0] subbed  [BLK_BYTES];

    always_comb begin
        for (int i = 0; i < BLK_BYTES; i++) begin
            shifted[i] = din[8*((i + 4*(i % 4)) % BLK_BYTES) +: 8];
        end
    end

    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_sb
        aegis_sbox u_sb (.din(shifted[g]), .dout(subbed[g]));
    end

    always_comb begin
        dout = '0;
        for (int c = 0; c < NCOL; c++) begin
            for (int r = 0; r < 4; r++) begin
                dout[8*(4*c + r) +: 8] =
                    xtime(subbed[4*c + r]) ^
                    xtime(subbed[4*c + (r+1)%4]) ^ subbed[4*c + (r+1)%4] ^
                    subbed[4*c + (r+2)%4] ^ subbed[4*c + (r+3)%4];
            end
        end
    end
endmodule

// File: rtl/aegis128_state_engine.sv
module aegis128_state_engine
    import aegis_pkg::*;
#(
    parameter int INIT_STEPS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_start,
    input  logic [BLK_W-1:0]      key,
    input  logic [BLK_W-1:0]      iv,
    input  logic                  upd_valid,
    input  logic [BLK_W-1:0]      upd_msg,
    output logic [NWORDS*BLK_W-1:0] state_out,
    output logic                  busy,
    output logic                  init_done
);
    localparam int CNT_W = $clog2(INIT_STEPS + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(INIT_STEPS - 1);

    typedef struct packed {
        state_t           st;
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;
    blk_t  rnd_out [NWORDS];
    blk_t  absorb;
    state_t stepped;
    blk_t  kiv;

    for (genvar j = 0; j < NWORDS; j++) begin : g_rnd
        aegis_aes_round u_rnd (.din(r_q.st[j]), .dout(rnd_out[j]));
    end

    always_comb begin
        kiv = key ^ iv;
        if (r_q.busy) absorb = r_q.cnt[0] ? kiv : key;
        else          absorb = upd_msg;

        stepped[0] = r_q.st[0] ^ rnd_out[NWORDS-1] ^ absorb;
        for (int j = 1; j < NWORDS; j++) begin
            stepped[j] = r_q.st[j] ^ rnd_out[j-1];
        end

        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.busy) begin
            r_d.st  = stepped;
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == LAST_STEP) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.cnt  = '0;
            end
        end else if (init_start) begin
            r_d.st[0] = kiv;
            r_d.st[1] = CONST1;
            r_d.st[2] = CONST0;
            r_d.st[3] = key ^ CONST0;
            r_d.st[4] = key ^ CONST1;
            r_d.busy  = 1'b1;
            r_d.cnt   = '0;
        end else if (upd_valid) begin
            r_d.st = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_out = r_q.st;
    assign busy      = r_q.busy;
    assign init_done = r_q.done;
endmodule

// File: rtl/aegis128_state_engine_chk.sv
module aegis128_state_engine_chk #(
    parameter int INIT_STEPS = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         init_start,
    input logic [127:0] key,
    input logic [127:0] iv,
    input logic         upd_valid,
    input logic [639:0] state_out,
    input logic         busy,
    input logic         init_done
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == INIT_STEPS);

    a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= INIT_STEPS);

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!busy && $past(busy)));

    a_r2_load_word0: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && init_start) |=> (busy && state_out[127:0] == $past(key ^ iv)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !init_start && !upd_valid) |=> $stable(state_out));
endmodule

bind aegis128_state_engine aegis128_state_engine_chk #(.INIT_STEPS(INIT_STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .key(key), .iv(iv),
    .upd_valid(upd_valid), .state_out(state_out), .busy(busy), .init_done(init_done)
);

// File: tb/aegis128_state_engine_test.sv
`timescale 1ns/1ps
module aegis128_state_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] iv = '0;
    logic         upd_valid = 1'b0;
    logic [127:0] upd_msg = '0;
    logic [639:0] state_out;
    logic         busy;
    logic         init_done;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    aegis128_state_engine uut (
        .clk(clk), .rst_n(rst_n), .init_start(init_start), .key(key), .iv(iv),
        .upd_valid(upd_valid), .upd_msg(upd_msg), .state_out(state_out),
        .busy(busy), .init_done(init_done)
    );

    // ---------------- behavioural reference ----------------
    byte unsigned sb [256];
    byte unsigned sr_idx [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
    byte unsigned c0b [16] = '{8'h00,8'h01,8'h01,8'h02,8'h03,8'h05,8'h08,8'h0d,
                               8'h15,8'h22,8'h37,8'h59,8'h90,8'he9,8'h79,8'h62};
    byte unsigned c1b [16] = '{8'hdb,8'h3d,8'h18,8'h55,8'h6d,8'hc2,8'h2f,8'hf1,
                               8'h20,8'h11,8'h31,8'h42,8'h73,8'hb5,8'h28,8'hdd};

    function automatic int rl(input int v, input int n);
        return ((v << n) | (v >> (8 - n))) & 255;
    endfunction

    initial begin
        int p;
        int q;
        int x;
        p = 1;
        q = 1;
        do begin
            p = (p ^ (p << 1) ^ (((p & 128) != 0) ? 27 : 0)) & 255;
            q = (q ^ (q << 1)) & 255;
            q = (q ^ (q << 2)) & 255;
            q = (q ^ (q << 4)) & 255;
            if ((q & 128) != 0) q = q ^ 9;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = byte'(x ^ 8'h63);
        end while (p != 1);
        sb[0] = 8'h63;
    end

    function automatic int gm(input int a, input int b);
        int r;
        r = 0;
        for (int i = 0; i < 8; i++) begin
            if (((b >> i) & 1) != 0) r = r ^ a;
            a = (a << 1) & 511;
            if (a > 255) a = (a ^ 27) & 255;
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_round(input logic [127:0] w);
        int t [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) t[i] = sb[w[8*sr_idx[i] +: 8]];
        for (int c = 0; c < 4; c++) begin
            o[8*(4*c)   +: 8] = 8'(gm(2,t[4*c])   ^ gm(3,t[4*c+1]) ^ t[4*c+2] ^ t[4*c+3]);
            o[8*(4*c+1) +: 8] = 8'(t[4*c]   ^ gm(2,t[4*c+1]) ^ gm(3,t[4*c+2]) ^ t[4*c+3]);
            o[8*(4*c+2) +: 8] = 8'(t[4*c]   ^ t[4*c+1] ^ gm(2,t[4*c+2]) ^ gm(3,t[4*c+3]));
            o[8*(4*c+3) +: 8] = 8'(gm(3,t[4*c]) ^ t[4*c+1] ^ t[4*c+2] ^ gm(2,t[4*c+3]));
        end
        return o;
    endfunction

    function automatic logic [639:0] ref_update(input logic [639:0] s, input logic [127:0] m);
        logic [639:0] n;
        n[127:0]   = s[127:0]   ^ ref_round(s[639:512]) ^ m;
        n[255:128] = s[255:128] ^ ref_round(s[127:0]);
        n[383:256] = s[383:256] ^ ref_round(s[255:128]);
        n[511:384] = s[511:384] ^ ref_round(s[383:256]);
        n[639:512] = s[639:512] ^ ref_round(s[511:384]);
        return n;
    endfunction

    function automatic logic [127:0] pack16(input byte unsigned b [16]);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = b[i];
        return v;
    endfunction

    logic [639:0] m_state;
    logic         m_busy;
    logic         m_done;
    int           m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= '0; m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                m_state <= ref_update(m_state, (m_cnt % 2 == 0) ? key : (key ^ iv));
                if (m_cnt == 9) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_cnt <= 0;
                end else m_cnt <= m_cnt + 1;
            end else if (init_start) begin
                m_state <= {key ^ pack16(c1b), key ^ pack16(c0b), pack16(c0b),
                            pack16(c1b), key ^ iv};
                m_busy <= 1'b1;
                m_cnt  <= 0;
            end else if (upd_valid) begin
                m_state <= ref_update(m_state, upd_msg);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string what, input logic [639:0] act, input logic [639:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk({tag, " state"}, state_out, m_state);
        chk({tag, " busy"}, 640'(busy), 640'(m_busy));
        chk({tag, " done"}, 640'(init_done), 640'(m_done));
    endtask

    // advance one clock and compare 5 ns after the edge
    task automatic tick();
        @(posedge clk);
        #5;
        compare_all();
    endtask

    task automatic run_init(input logic [127:0] k, input logic [127:0] v,
                            input int poke_cycle);
        key = k; iv = v;
        init_start = 1'b1;
        tag = "R2";
        tick();
        init_start = 1'b0;
        chk("R2 loaded S0", 640'(state_out[127:0]), 640'(k ^ v));
        chk("R2 loaded S2", 640'(state_out[383:256]), 640'(pack16(c0b)));
        for (int i = 0; i < 10; i++) begin
            tag = "R3";
            chk("R3 busy during setup", 640'(busy), 640'(1'b1));
            if (i == poke_cycle || i == 9) begin
                tag = "R6";
                upd_valid = 1'b1; upd_msg = {4{$urandom}};
                init_start = (i == 9);
            end else tag = "R4";
            tick();
            upd_valid = 1'b0; init_start = 1'b0;
        end
        tag = "R3";
        chk("R3 busy low after ten", 640'(busy), 640'(1'b0));
        chk("R3 done pulse", 640'(init_done), 640'(1'b1));
        tag = "R4";
        tick();
        chk("R3 done one cycle", 640'(init_done), 640'(1'b0));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #35;
        tag = "R1";
        compare_all();
        chk("R1 reset state", state_out, '0);
        chk("R1 reset busy", 640'(busy), 640'(1'b0));
        rst_n = 1'b1;
        tick();

        // R5: zero state, zero word -> every byte 0x63
        tag = "R5";
        upd_valid = 1'b1; upd_msg = '0;
        tick();
        chk("R5 zero-state step", state_out, {80{8'h63}});
        upd_msg = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        tick();
        for (int i = 0; i < 20; i++) begin
            upd_msg = {$urandom, $urandom, $urandom, $urandom};
            upd_valid = (i % 3 != 2);
            tag = upd_valid ? "R5" : "R7";
            tick();
        end
        upd_valid = 1'b0;
        tag = "R7";
        begin
            logic [639:0] held;
            held = state_out;
            tick(); tick();
            chk("R7 idle hold", state_out, held);
        end

        run_init(128'h000102030405060708090a0b0c0d0e0f,
                 128'hf0e0d0c0b0a090807060504030201000, 0);

        // R8: simultaneous start and update while idle
        tag = "R8";
        key = {4{$urandom}}; iv = {4{$urandom}};
        init_start = 1'b1; upd_valid = 1'b1; upd_msg = {4{$urandom}};
        tick();
        init_start = 1'b0; upd_valid = 1'b0;
        chk("R8 start wins", 640'(state_out[127:0]), 640'(key ^ iv));
        chk("R8 busy", 640'(busy), 640'(1'b1));
        for (int i = 0; i < 11; i++) tick();

        run_init({4{32'hdeadbeef}}, {4{32'h13579bdf}}, 4);

        tag = "R5";
        for (int i = 0; i < 8; i++) begin
            upd_valid = 1'b1; upd_msg = {$urandom, $urandom, $urandom, $urandom};
            tick();
        end
        upd_valid = 1'b0;
        tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule